// File: doc/BRIEF.md
# Decimal Accumulator Processor

A small stored-program processor that computes on three-digit decimal numbers held as BCD, three nibbles per word. It owns a 100-word program and data store, one accumulator, and a two-digit BCD program counter. Execution is a repeating loop with three steps. First the counter value is copied to a fetch address and the counter is stepped by one. Next the word at the fetch address is read into an instruction register. Last that instruction is carried out, reading its operand from memory when it needs one.

Software is placed in the store through a load port, which works only while the core is held in reset. Once reset is released, the program runs from address 00. It talks to the outside world only through an input port and an output port, each with a valid/ready handshake. It runs until it reaches a halt, which stops it until the next reset. The accumulator and status flags are brought out as ports so that results can be observed.

Top module: `deccalc_core`

## Requirements
- R1: The store holds 100 words at BCD addresses 00..99. A load-port write (`ld_we`) takes effect only while the core is held in reset and only when both address digits are 0..9. Writes at any other time, or with a digit above 9, change nothing.
- R2: While reset is held, and right after it, the counter reads 00, the accumulator reads 000, zero=1, negative=0, error=0, halted=0, and neither handshake is offered. The first instruction is taken from address 00.
- R3: Each instruction is fetched from the current counter value, and the counter is stepped by one in BCD, wrapping from 99 to 00.
- R4: Opcode digit 1 (1aa) adds word aa to the accumulator in BCD. A sum above 999 keeps only its low three digits and sets the error flag.
- R5: Opcode digit 2 (2aa) subtracts word aa from the accumulator. A negative result is stored as its 1000-complement and sets the negative flag; a result of zero or more clears it.
- R6: 3aa copies the accumulator into word aa; 5aa copies word aa into the accumulator.
- R7: 6aa always jumps to aa. 7aa jumps only when the accumulator is 000. 8aa jumps only when the negative flag is clear. A jump not taken goes on to the next address.
- R8: 901 raises `in_ready` and waits, with the accumulator unchanged, until `in_valid` is seen. It then loads `in_data` into the accumulator and drops `in_ready`.
- R9: 902 raises `out_valid` with the accumulator value on `out_data`. It holds both steady until `out_ready` is seen.
- R10: zero is high exactly when the accumulator is 000. Load, input and add clear negative. positive is high when both zero and negative are low. error stays set until reset.
- R11: Any instruction with opcode digit 0 halts. `halted` then stays high, and the counter and accumulator stay frozen until reset.
- R12: Opcode digit 4, and opcode 9 with a low part other than 01 or 02, set the error flag and halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ld_we | input | 1 | Load-port write strobe |
| ld_addr | input | 8 | Load-port BCD address (tens nibble high) |
| ld_data | input | 12 | Load-port BCD word |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Core waiting for input |
| in_data | input | 12 | Input BCD word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Output taken |
| out_data | output | 12 | Output BCD word |
| pc | output | 8 | Program counter, two BCD digits |
| acc | output | 12 | Accumulator, three BCD digits |
| flag_pos | output | 1 | Accumulator positive |
| flag_neg | output | 1 | Last subtraction went below zero |
| flag_zero | output | 1 | Accumulator is 000 |
| flag_err | output | 1 | Sticky error |
| halted | output | 1 | Core stopped |

## Verification
The assertions that the accumulator always holds valid BCD digits assume that every word loaded into the store and every word offered on `in_data` uses digits 0..9. The bench only ever loads and feeds such words. The single deliberate bad address, a ones digit of A, appears only on the load port, where it must be rejected.

The handshake assertions assume that `out_ready` and `in_valid` may be held low for any length of time. The bench drives `out_ready` high only one cycle in three, and holds off `in_valid` for several cycles, so that both stall paths are exercised.

// File: rtl/deccalc_pkg.sv
package deccalc_pkg;

  localparam int DIGITS    = 3;
  localparam int WORD_W    = 4 * DIGITS;
  localparam int ADDR_W    = 8;
  localparam int MEM_WORDS = 100;
  localparam int IDX_W     = $clog2(MEM_WORDS);

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_STOP   = 2'd3
  } core_state_t;

  localparam logic [3:0] OPC_STOP  = 4'd0;
  localparam logic [3:0] OPC_ADD   = 4'd1;
  localparam logic [3:0] OPC_SUB   = 4'd2;
  localparam logic [3:0] OPC_STORE = 4'd3;
  localparam logic [3:0] OPC_LOAD  = 4'd5;
  localparam logic [3:0] OPC_JUMP  = 4'd6;
  localparam logic [3:0] OPC_JZERO = 4'd7;
  localparam logic [3:0] OPC_JNNEG = 4'd8;
  localparam logic [3:0] OPC_PORT  = 4'd9;

  localparam logic [7:0] PORT_IN   = 8'h01;
  localparam logic [7:0] PORT_OUT  = 8'h02;

  function automatic logic bcd2_ok(input logic [7:0] a);
    return (a[7:4] <= 4'd9) && (a[3:0] <= 4'd9);
  endfunction

  function automatic logic [IDX_W-1:0] bcd2_index(input logic [7:0] a);
    logic [IDX_W-1:0] tens;
    logic [IDX_W-1:0] ones;
    tens = IDX_W'(a[7:4]);
    ones = IDX_W'(a[3:0]);
    if (!bcd2_ok(a)) return '0;
    return IDX_W'(tens * IDX_W'(10)) + ones;
  endfunction

  function automatic logic [7:0] bcd2_step(input logic [7:0] a);
    logic [7:0] r;
    if (a[3:0] >= 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = (a[7:4] >= 4'd9) ? 4'd0 : a[7:4] + 4'd1;
    end else begin
      r[3:0] = a[3:0] + 4'd1;
      r[7:4] = a[7:4];
    end
    return r;
  endfunction

endpackage

// File: rtl/deccalc_bcd_alu.sv
module deccalc_bcd_alu #(
  parameter int DIGITS = 3,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         carry
);

  logic [DIGITS:0] cy;

  assign cy[0] = sub;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [3:0] da;
    logic [3:0] db;
    logic [3:0] db_eff;
    logic [4:0] raw;
    logic [4:0] adj;

    assign da     = opa[4*d +: 4];
    assign db     = opb[4*d +: 4];
    assign db_eff = sub ? (4'd9 - db) : db;
    assign raw    = {1'b0, da} + {1'b0, db_eff} + {4'b0, cy[d]};
    assign cy[d+1] = (raw > 5'd9);
    assign adj    = cy[d+1] ? (raw + 5'd6) : raw;
    assign res[4*d +: 4] = adj[3:0];
  end

  assign carry = cy[DIGITS];

endmodule

// File: rtl/deccalc_store.sv
module deccalc_store #(
  parameter int WORDS = 100,
  parameter int DW    = 12,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [IW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_b
);

  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx <= LAST)) begin
      cells[wr_idx] <= wr_data;
    end
  end

  assign rd_data_a = (rd_idx_a <= LAST) ? cells[rd_idx_a] : '0;
  assign rd_data_b = (rd_idx_b <= LAST) ? cells[rd_idx_b] : '0;

endmodule

// File: rtl/deccalc_ctrl.sv
module deccalc_ctrl
  import deccalc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [WORD_W-1:0] opnd_word,
  input  logic [WORD_W-1:0] alu_res,
  input  logic              alu_carry,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] instr_addr,
  output logic [ADDR_W-1:0] opnd_addr,
  output logic              alu_sub,
  output logic              st_we,
  output logic [WORD_W-1:0] st_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] acc,
  output logic              flag_pos,
  output logic              flag_neg,
  output logic              flag_zero,
  output logic              flag_err,
  output logic              halted
);

  core_state_t       state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [WORD_W-1:0] ir_q, ir_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              neg_q, neg_d;
  logic              err_q, err_d;

  logic [3:0]        op;
  logic [ADDR_W-1:0] adr;
  logic              acc_is_zero;
  logic              undefined_op;

  assign op          = ir_q[WORD_W-1 -: 4];
  assign adr         = ir_q[ADDR_W-1:0];
  assign acc_is_zero = (acc_q == '0);
  assign undefined_op = (op == 4'd4) || (op > OPC_PORT) ||
                        ((op == OPC_PORT) && (adr != PORT_IN) && (adr != PORT_OUT));

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    mar_d     = mar_q;
    ir_d      = ir_q;
    acc_d     = acc_q;
    neg_d     = neg_q;
    err_d     = err_q;
    st_we     = 1'b0;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    alu_sub   = (op == OPC_SUB);

    unique case (state_q)
      ST_FETCH: begin
        mar_d   = pc_q;
        pc_d    = bcd2_step(pc_q);
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        ir_d    = instr_word;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        if (undefined_op) begin
          err_d   = 1'b1;
          state_d = ST_STOP;
        end else begin
          unique case (op)
            OPC_ADD: begin
              acc_d = alu_res;
              neg_d = 1'b0;
              if (alu_carry) err_d = 1'b1;
            end
            OPC_SUB: begin
              acc_d = alu_res;
              neg_d = !alu_carry;
            end
            OPC_STORE: st_we = 1'b1;
            OPC_LOAD: begin
              acc_d = opnd_word;
              neg_d = 1'b0;
            end
            OPC_JUMP:  pc_d = adr;
            OPC_JZERO: if (acc_is_zero) pc_d = adr;
            OPC_JNNEG: if (!neg_q) pc_d = adr;
            OPC_PORT: begin
              if (adr == PORT_IN) begin
                in_ready = 1'b1;
                if (in_valid) begin
                  acc_d = in_data;
                  neg_d = 1'b0;
                end else begin
                  state_d = ST_EXEC;
                end
              end else begin
                out_valid = 1'b1;
                if (!out_ready) state_d = ST_EXEC;
              end
            end
            default: state_d = ST_STOP;
          endcase
        end
      end
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      mar_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      neg_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      mar_q   <= mar_d;
      ir_q    <= ir_d;
      acc_q   <= acc_d;
      neg_q   <= neg_d;
      err_q   <= err_d;
    end
  end

  assign instr_addr = mar_q;
  assign opnd_addr  = adr;
  assign st_data    = acc_q;
  assign out_data   = acc_q;
  assign pc         = pc_q;
  assign acc        = acc_q;
  assign flag_neg   = neg_q;
  assign flag_zero  = acc_is_zero;
  assign flag_pos   = !neg_q && !acc_is_zero;
  assign flag_err   = err_q;
  assign halted     = (state_q == ST_STOP);

  AST_PC_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q[7:4] <= 4'd9) && (pc_q[3:0] <= 4'd9)); // R3

  AST_ACC_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q[11:8] <= 4'd9) && (acc_q[7:4] <= 4'd9) && (acc_q[3:0] <= 4'd9)); // R4

  AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc_q) && $stable(acc_q)); // R11

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R9

  AST_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready && $stable(acc_q)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_err |=> flag_err); // R10

  AST_UNDEF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_EXEC) && undefined_op) |=> halted && flag_err); // R12

  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R8

endmodule

// File: rtl/deccalc_core.sv
module deccalc_core
  import deccalc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_we,
  input  logic [7:0]  ld_addr,
  input  logic [11:0] ld_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [11:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [11:0] out_data,
  output logic [7:0]  pc,
  output logic [11:0] acc,
  output logic        flag_pos,
  output logic        flag_neg,
  output logic        flag_zero,
  output logic        flag_err,
  output logic        halted
);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;

  logic [ADDR_W-1:0] instr_addr;
  logic [ADDR_W-1:0] opnd_addr;
  logic [WORD_W-1:0] instr_word;
  logic [WORD_W-1:0] opnd_word;
  logic [WORD_W-1:0] alu_res;
  logic              alu_carry;
  logic              alu_sub;
  logic              st_we;
  logic [WORD_W-1:0] st_data;

  logic              mem_we;
  logic [IDX_W-1:0]  mem_widx;
  logic [WORD_W-1:0] mem_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign core_rst_n = rst_sync_q[1];

  always_comb begin
    if (!core_rst_n) begin
      mem_we    = ld_we && bcd2_ok(ld_addr);
      mem_widx  = bcd2_index(ld_addr);
      mem_wdata = ld_data;
    end else begin
      mem_we    = st_we;
      mem_widx  = bcd2_index(opnd_addr);
      mem_wdata = st_data;
    end
  end

  deccalc_store #(
    .WORDS (MEM_WORDS),
    .DW    (WORD_W)
  ) i_store (
    .clk       (clk),
    .wr_en     (mem_we),
    .wr_idx    (mem_widx),
    .wr_data   (mem_wdata),
    .rd_idx_a  (bcd2_index(instr_addr)),
    .rd_data_a (instr_word),
    .rd_idx_b  (bcd2_index(opnd_addr)),
    .rd_data_b (opnd_word)
  );

  deccalc_bcd_alu #(
    .DIGITS (DIGITS)
  ) i_alu (
    .opa   (acc),
    .opb   (opnd_word),
    .sub   (alu_sub),
    .res   (alu_res),
    .carry (alu_carry)
  );

  deccalc_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .instr_word (instr_word),
    .opnd_word  (opnd_word),
    .alu_res    (alu_res),
    .alu_carry  (alu_carry),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_ready  (out_ready),
    .instr_addr (instr_addr),
    .opnd_addr  (opnd_addr),
    .alu_sub    (alu_sub),
    .st_we      (st_we),
    .st_data    (st_data),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .pc         (pc),
    .acc        (acc),
    .flag_pos   (flag_pos),
    .flag_neg   (flag_neg),
    .flag_zero  (flag_zero),
    .flag_err   (flag_err),
    .halted     (halted)
  );

  AST_NO_STORE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> !st_we); // R1

endmodule

// File: tb/test_deccalc_core.sv
module test_deccalc_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we;
  logic [7:0]  ld_addr;
  logic [11:0] ld_data;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [11:0] out_data;
  logic [7:0]  pc;
  logic [11:0] acc;
  logic        flag_pos, flag_neg, flag_zero, flag_err, halted;

  always #10 clk = ~clk;

  deccalc_core i_deccalc_core (
    .clk (clk), .rst_n (rst_n),
    .ld_we (ld_we), .ld_addr (ld_addr), .ld_data (ld_data),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
    .pc (pc), .acc (acc),
    .flag_pos (flag_pos), .flag_neg (flag_neg), .flag_zero (flag_zero),
    .flag_err (flag_err), .halted (halted)
  );

  typedef struct packed {
    logic [11:0] data;
    logic        neg;
    logic        err;
  } out_item_t;

  out_item_t   exp_q[$];
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;
  bit          hold_v = 0;
  logic [11:0] hold_d;
  int          rcnt = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_out(input logic [11:0] d, input logic n, input logic e);
    exp_q.push_back('{data: d, neg: n, err: e});
  endtask

  function automatic logic [7:0] bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  // output sink: ready one cycle in three, changed away from the sampling edge
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      rcnt++;
      out_ready = (rcnt % 3 == 0);
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && hold_v && !out_valid) chk("R9 valid dropped before ready", 0, 1);
    if (rst_n && out_valid) begin
      if (hold_v) chk("R9 out_data held while stalled", out_data, hold_d);
      if (out_ready) begin
        hold_v = 0;
        if (exp_q.size() == 0) begin
          chk("R9 unexpected output word", out_data, 12'hFFF);
        end else begin
          out_item_t it;
          it = exp_q.pop_front();
          chk("R9 output word", out_data, it.data);
          chk("R5 negative flag at output", flag_neg, it.neg);
          chk("R10 error flag at output", flag_err, it.err);
        end
      end else begin
        hold_v = 1;
        hold_d = out_data;
      end
    end else begin
      hold_v = 0;
    end
  end

  task automatic ld(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    ld_we = 1'b1;
    ld_addr = a;
    ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    ld_we = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset pc", pc, 8'h00);
    chk("R2 reset acc", acc, 12'h000);
    chk("R2 reset zero flag", flag_zero, 1);
    chk("R2 reset negative flag", flag_neg, 0);
    chk("R10 reset clears error", flag_err, 0);
    chk("R2 reset not halted", halted, 0);
    chk("R2 reset no handshake", {out_valid, in_ready}, 2'b00);
    for (int i = 0; i < 100; i++) ld(bcd(i), 12'h000);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_stop(input string tag);
    int n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " reached halt"}, halted, 1);
  endtask

  task automatic feed_input(input logic [11:0] v);
    int n = 0;
    while (!in_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 in_ready held while waiting", in_ready, 1);
      chk("R8 acc unchanged while waiting", acc, 12'h000);
    end
    in_valid = 1'b1;
    in_data = v;
    @(negedge clk);
    chk("R8 acc takes input word", acc, v);
    chk("R8 in_ready drops after transfer", in_ready, 0);
    in_valid = 1'b0;
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ld_we = 1'b0;
    ld_addr = 8'h00;
    ld_data = 12'h000;
    in_valid = 1'b0;
    in_data = 12'h000;

    // Program A: input, add, subtract below zero, store/load, add overflow
    enter_reset();
    ld(8'h00, 12'h901); ld(8'h01, 12'h160); ld(8'h02, 12'h902);
    ld(8'h03, 12'h261); ld(8'h04, 12'h902); ld(8'h05, 12'h810);
    ld(8'h06, 12'h362); ld(8'h07, 12'h562); ld(8'h08, 12'h902);
    ld(8'h09, 12'h163); ld(8'h10, 12'h902); ld(8'h11, 12'h000);
    ld(8'h60, 12'h456); ld(8'h61, 12'h600); ld(8'h63, 12'h050);
    push_out(12'h579, 0, 0);  // R4 123+456
    push_out(12'h979, 1, 0);  // R5 579-600 -> 1000-complement
    push_out(12'h979, 0, 0);  // R6 stored then loaded, R7 jump not taken
    push_out(12'h029, 0, 1);  // R4 overflow wraps, error set
    release_reset();
    fork
      wait_stop("R11 program A");
      feed_input(12'h123);
    join
    repeat (4) @(negedge clk);
    chk("R11 pc after halt at 11", pc, 8'h12);
    chk("R11 acc frozen", acc, 12'h029);
    chk("R10 positive flag", flag_pos, 1);
    chk("R10 zero flag low", flag_zero, 0);
    chk("R10 error sticky", flag_err, 1);
    chk("R9 all outputs seen A", exp_q.size(), 0);

    // Program B: conditional jumps, undefined opcode, bad load address
    enter_reset();
    ld(8'h00, 12'h564); ld(8'h01, 12'h710); ld(8'h02, 12'h000);
    ld(8'h10, 12'h902); ld(8'h11, 12'h165); ld(8'h12, 12'h715);
    ld(8'h13, 12'h817); ld(8'h14, 12'h000); ld(8'h17, 12'h620);
    ld(8'h20, 12'h902); ld(8'h21, 12'h400);
    ld(8'h64, 12'h000); ld(8'h65, 12'h007);
    ld(8'h1A, 12'h000);       // R1 ones digit above 9 must not land anywhere
    push_out(12'h000, 0, 0);  // R7 jump on zero taken
    push_out(12'h007, 0, 0);  // R7 zero not taken, non-negative taken, always
    release_reset();
    wait_stop("R12 program B");
    repeat (4) @(negedge clk);
    chk("R12 pc after undefined at 21", pc, 8'h22);
    chk("R12 error set by undefined opcode", flag_err, 1);
    chk("R12 acc kept", acc, 12'h007);
    chk("R9 all outputs seen B", exp_q.size(), 0);

    // Program C: counter wrap 99->00, subtract to non-negative, load while running
    enter_reset();
    ld(8'h00, 12'h797); ld(8'h01, 12'h000);
    ld(8'h97, 12'h566); ld(8'h98, 12'h267); ld(8'h99, 12'h902);
    ld(8'h66, 12'h321); ld(8'h67, 12'h300);
    push_out(12'h021, 0, 0);  // R5 non-negative difference clears negative
    release_reset();
    repeat (6) @(negedge clk);
    ld(8'h01, 12'h902);       // R1 write while running must be ignored
    wait_stop("R3 program C");
    repeat (4) @(negedge clk);
    chk("R3 pc wrapped and halted at 01", pc, 8'h02);
    chk("R1 running write ignored, acc", acc, 12'h021);
    chk("R10 no error", flag_err, 0);
    chk("R9 all outputs seen C", exp_q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule